// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block sits at the serial pins of a flash device and turns a select-framed bit stream into one decoded read command. The host lowers chip select and shifts in an 8-bit opcode, then three address bytes, then, for the faster read variants, one dummy byte. All of them arrive most significant bit first and are taken on rising serial clock edges. Once the last header bit has been taken, the block gives downstream logic a single-cycle strobe. The strobe carries the opcode, a 21-bit start address and the number of data lanes the reply will use. Every event is counted in a fast system clock domain, and the serial pins are sampled in that domain.

The block recognises four opcodes. A plain read (03h) has no dummy byte and uses one lane. A fast read (0Bh), a dual-output read (3Bh) and a quad-output read (6Bh) each take a dummy byte and reply on one, two or four lanes. When any other opcode arrives, the block ignores the rest of that frame. When a frame is cut short by deselect, it is dropped. An active-low pause input freezes parsing in the middle of a frame and asks the output drivers to release the pins. The pause can begin only while the serial clock is low.

Top module: `sfe_cmd_frontend`

## Requirements
- R1: After reset, with chip select high, `cmd_valid` is 0 and `io_release` is 1.
- R2: Opcode 03h issues its strobe right after the 24th address bit, with lane code 0 (one lane) and no dummy byte.
- R3: Opcodes 0Bh, 3Bh and 6Bh issue their strobe only after 8 further dummy bits have followed the address. Their lane codes are 0, 1 and 2 (one, two and four lanes); code 3 never appears.
- R4: Of the 24 address bits received, the first three are dropped. `cmd_addr` equals the received value modulo 200000h.
- R5: Opcode and address are assembled most significant bit first.
- R6: After an unrecognised opcode, no strobe is issued for the rest of that frame, whatever bits follow. The next frame is parsed normally.
- R7: If chip select rises before the header is complete, no strobe is issued, and the next frame starts again from the opcode.
- R8: While paused (`hold_n` low and the pause accepted), `io_release` is 1 and rising clock edges are not counted. When the pause ends, parsing resumes from the bit where it stopped.
- R9: A pause request made while the serial clock is high is not accepted until the clock goes low.
- R10: Both clock idle levels are accepted. Lowering chip select while the serial clock is high creates no edge.
- R11: Exactly one strobe is issued per frame. Clock edges after the header do not issue another.
- R12: `cmd_valid` lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, frames a command |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| cmd_valid | output | 1 | Single-cycle command strobe |
| cmd_opcode | output | 8 | Opcode of the issued command |
| cmd_addr | output | 21 | Start address |
| cmd_lanes | output | 2 | Reply width: 0 one lane, 1 two, 2 four |
| io_release | output | 1 | Request to tri-state the serial outputs (deselected or paused) |

## Verification
Two conditions are hard to reach from the ports. The first is a pause that lands in the middle of the address with clock edges arriving while it is active. The bench stops after 12 address bits, drops `hold_n` with the clock low, toggles the clock with data that would corrupt the address, and then finishes the remaining bits. The second is the lockout after an unknown opcode. To test it, the bench follows the unknown opcode, in the same frame, with a complete and valid read header, so that any leak in the lockout would show up as a strobe.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int OPC_BITS     = 8;
    localparam int ADDR_IN_BITS = 24;
    localparam int ADDR_BITS    = 21;
    localparam int DUMMY_BITS   = 8;
    localparam int CNT_W        = $clog2(ADDR_IN_BITS);

    localparam logic [7:0] OP_RD_SLOW = 8'h03;
    localparam logic [7:0] OP_RD_FAST = 8'h0B;
    localparam logic [7:0] OP_RD_DUAL = 8'h3B;
    localparam logic [7:0] OP_RD_QUAD = 8'h6B;

    typedef enum logic [1:0] {
        LANES_X1 = 2'd0,
        LANES_X2 = 2'd1,
        LANES_X4 = 2'd2
    } lanes_e;

    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_LOCK   = 3'd4
    } phase_e;

    typedef struct packed {
        logic   known;
        logic   dummy;
        lanes_e lanes;
    } op_info_t;

    typedef struct packed {
        logic [OPC_BITS-1:0]  opcode;
        logic [ADDR_BITS-1:0] addr;
        lanes_e               lanes;
    } cmd_t;

    function automatic op_info_t classify(input logic [OPC_BITS-1:0] op);
        op_info_t r;
        r = '{known: 1'b0, dummy: 1'b0, lanes: LANES_X1};
        case (op)
            OP_RD_SLOW: r = '{known: 1'b1, dummy: 1'b0, lanes: LANES_X1};
            OP_RD_FAST: r = '{known: 1'b1, dummy: 1'b1, lanes: LANES_X1};
            OP_RD_DUAL: r = '{known: 1'b1, dummy: 1'b1, lanes: LANES_X2};
            OP_RD_QUAD: r = '{known: 1'b1, dummy: 1'b1, lanes: LANES_X4};
            default:    r = '{known: 1'b0, dummy: 1'b0, lanes: LANES_X1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfe_sck_gate.sv
module sfe_sck_gate (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic rise,
    output logic held
);

    logic sck_q;
    logic held_q;

    // The previous clock level is tracked at all times, so a clock that
    // idles high leaves no stale low level behind when select falls.
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            sck_q <= sck;
            if (cs_n) begin
                held_q <= 1'b0;
            end else if (!held_q) begin
                if (!hold_n && !sck) begin
                    held_q <= 1'b1;
                end
            end else if (hold_n && !sck) begin
                held_q <= 1'b0;
            end
        end
    end

    assign rise = sck & ~sck_q & ~cs_n & ~held_q;
    assign held = held_q;

endmodule

// File: rtl/sfe_frame_parser.sv
module sfe_frame_parser
    import sfe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   rise,
    input  logic   si,
    output logic   cmd_valid,
    output cmd_t   cmd,
    output phase_e phase
);

    phase_e                 phase_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [OPC_BITS-1:0]    opc_q;
    logic [ADDR_BITS-1:0]   addr_q;
    op_info_t               info_q;
    logic                   valid_q;
    cmd_t                   cmd_q;

    logic [OPC_BITS-1:0]    opc_next;
    logic [ADDR_BITS-1:0]   addr_next;
    op_info_t               info_next;
    logic                   last_opc;
    logic                   last_addr;
    logic                   last_dummy;
    logic                   issue;
    cmd_t                   cmd_next;

    // Shifting 24 bits through a 21-bit register keeps only the low
    // 21 address bits; the top three bits fall off the end.
    always_comb begin
        opc_next   = {opc_q[OPC_BITS-2:0], si};
        addr_next  = {addr_q[ADDR_BITS-2:0], si};
        info_next  = classify(opc_next);
        last_opc   = (cnt_q == CNT_W'(OPC_BITS - 1));
        last_addr  = (cnt_q == CNT_W'(ADDR_IN_BITS - 1));
        last_dummy = (cnt_q == CNT_W'(DUMMY_BITS - 1));
        issue      = 1'b0;
        cmd_next   = '{opcode: opc_q, addr: addr_q, lanes: info_q.lanes};
        if (rise) begin
            if (phase_q == PH_ADDR && last_addr && !info_q.dummy) begin
                issue    = 1'b1;
                cmd_next = '{opcode: opc_q, addr: addr_next, lanes: info_q.lanes};
            end else if (phase_q == PH_DUMMY && last_dummy) begin
                issue = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            phase_q <= PH_OPCODE;
            cnt_q   <= '0;
            opc_q   <= '0;
            addr_q  <= '0;
            info_q  <= '{known: 1'b0, dummy: 1'b0, lanes: LANES_X1};
            valid_q <= 1'b0;
        end else begin
            valid_q <= issue;
            if (rise) begin
                case (phase_q)
                    PH_OPCODE: begin
                        opc_q <= opc_next;
                        if (last_opc) begin
                            cnt_q   <= '0;
                            info_q  <= info_next;
                            phase_q <= info_next.known ? PH_ADDR : PH_LOCK;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= addr_next;
                        if (last_addr) begin
                            cnt_q   <= '0;
                            phase_q <= info_q.dummy ? PH_DUMMY : PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_DUMMY: begin
                        if (last_dummy) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        cnt_q <= cnt_q;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{opcode: '0, addr: '0, lanes: LANES_X1};
        end else if (issue) begin
            cmd_q <= cmd_next;
        end
    end

    assign cmd_valid = valid_q;
    assign cmd       = cmd_q;
    assign phase     = phase_q;

endmodule

// File: rtl/sfe_cmd_frontend.sv
module sfe_cmd_frontend
    import sfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 si,
    input  logic                 hold_n,
    output logic                 cmd_valid,
    output logic [OPC_BITS-1:0]  cmd_opcode,
    output logic [ADDR_BITS-1:0] cmd_addr,
    output logic [1:0]           cmd_lanes,
    output logic                 io_release
);

    logic   rise;
    logic   held;
    cmd_t   cmd;
    phase_e phase;

    sfe_sck_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .sck    (sck),
        .hold_n (hold_n),
        .rise   (rise),
        .held   (held)
    );

    sfe_frame_parser u_parse (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rise      (rise),
        .si        (si),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .phase     (phase)
    );

    assign cmd_opcode = cmd.opcode;
    assign cmd_addr   = cmd.addr;
    assign cmd_lanes  = cmd.lanes;
    assign io_release = cs_n | held;

endmodule

// File: rtl/sfe_cmd_frontend_chk.sv
module sfe_cmd_frontend_chk
    import sfe_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sck,
    input logic       held,
    input logic       cmd_valid,
    input logic [1:0] cmd_lanes,
    input phase_e     phase
);

    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_strobe_needs_select_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(cs_n));

    assert_lanes_legal_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_lanes != 2'd3));

    assert_no_strobe_from_pause_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(held));

    assert_pause_waits_low_clock_R9: assert property (@(posedge clk) disable iff (rst)
        (!held && sck) |=> !held);

    assert_lockout_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOCK) |=> !cmd_valid);

endmodule

bind sfe_cmd_frontend sfe_cmd_frontend_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sck       (sck),
    .held      (held),
    .cmd_valid (cmd_valid),
    .cmd_lanes (cmd_lanes),
    .phase     (phase)
);

// File: tb/sim_sfe_cmd_frontend.sv
`timescale 1ns/1ps
module sim_sfe_cmd_frontend;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        hold_n = 1'b1;
    logic        cmd_valid;
    logic [7:0]  cmd_opcode;
    logic [20:0] cmd_addr;
    logic [1:0]  cmd_lanes;
    logic        io_release;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    int doubles = 0;
    logic prev_valid = 1'b0;
    logic [7:0]  cap_op = '0;
    logic [20:0] cap_addr = '0;
    logic [1:0]  cap_lanes = '0;

    always #5 clk = ~clk;

    sfe_cmd_frontend u0 (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sck        (sck),
        .si         (si),
        .hold_n     (hold_n),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_addr   (cmd_addr),
        .cmd_lanes  (cmd_lanes),
        .io_release (io_release)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                strobes++;
                cap_op    = cmd_opcode;
                cap_addr  = cmd_addr;
                cap_lanes = cmd_lanes;
                if (prev_valid) doubles++;
            end
            prev_valid = cmd_valid;
        end
    end

    typedef struct packed {
        logic        mode3;
        logic [7:0]  op;
        logic [23:0] addr;
        logic        exp_valid;
        logic [1:0]  exp_lanes;
        logic [20:0] exp_addr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h03, 24'h123456, 1'b1, 2'd0, 21'h123456},
        '{1'b1, 8'h0B, 24'hFFFFFF, 1'b1, 2'd0, 21'h1FFFFF},
        '{1'b0, 8'h3B, 24'hA5A5A5, 1'b1, 2'd1, 21'h05A5A5},
        '{1'b1, 8'h6B, 24'hE00001, 1'b1, 2'd2, 21'h000001},
        '{1'b0, 8'h03, 24'h200000, 1'b1, 2'd0, 21'h000000},
        '{1'b0, 8'h9F, 24'h030000, 1'b0, 2'd0, 21'h000000},
        '{1'b1, 8'h0A, 24'h000000, 1'b0, 2'd0, 21'h000000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        @(negedge clk); sck = 1'b0; si = b;
        @(negedge clk);
        @(negedge clk); sck = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sbits(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic begin_frame(input logic m3);
        @(negedge clk); sck = m3;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_frame(input logic m3);
        @(negedge clk); sck = m3;
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cmd_valid after reset", 32'(cmd_valid), 32'd0);
        chk("R1", "io_release after reset", 32'(io_release), 32'd1);

        // Table walk: R2 R3 R4 R5 R10 R11
        for (int k = 0; k < NV; k++) begin
            base = strobes;
            begin_frame(VEC[k].mode3);
            sbits(24'(VEC[k].op), 8);
            sbits(VEC[k].addr, 24);
            sbits(24'h00, 8);
            sbits(24'hC33C, 16);
            end_frame(VEC[k].mode3);
            chk("R11", $sformatf("vec%0d strobe count", k), 32'(strobes - base),
                VEC[k].exp_valid ? 32'd1 : 32'd0);
            if (VEC[k].exp_valid) begin
                chk("R5", $sformatf("vec%0d opcode", k), 32'(cap_op), 32'(VEC[k].op));
                chk("R4", $sformatf("vec%0d address", k), 32'(cap_addr), 32'(VEC[k].exp_addr));
                chk("R3", $sformatf("vec%0d lanes", k), 32'(cap_lanes), 32'(VEC[k].exp_lanes));
            end
        end

        // R2: plain read fires straight after the address
        base = strobes;
        begin_frame(1'b0);
        sbits(24'h03, 8);
        sbits(24'h0ABCDE, 24);
        chk("R2", "strobe right after address", 32'(strobes - base), 32'd1);
        chk("R2", "address", 32'(cap_addr), 32'h0ABCDE);
        end_frame(1'b0);

        // R3: fast read waits for eight dummy bits
        base = strobes;
        begin_frame(1'b0);
        sbits(24'h0B, 8);
        sbits(24'h001234, 24);
        chk("R3", "no strobe before dummy", 32'(strobes - base), 32'd0);
        sbits(24'h00, 7);
        chk("R3", "no strobe after 7 dummy bits", 32'(strobes - base), 32'd0);
        sbits(24'h00, 1);
        chk("R3", "strobe after 8th dummy bit", 32'(strobes - base), 32'd1);
        end_frame(1'b0);

        // R7: early deselect, then a fresh frame
        base = strobes;
        begin_frame(1'b0);
        sbits(24'h03, 8);
        sbits(24'h1234, 16);
        end_frame(1'b0);
        chk("R7", "no strobe on partial frame", 32'(strobes - base), 32'd0);
        begin_frame(1'b0);
        sbits(24'h03, 8);
        sbits(24'h000010, 24);
        end_frame(1'b0);
        chk("R7", "next frame strobes", 32'(strobes - base), 32'd1);
        chk("R7", "next frame address", 32'(cap_addr), 32'h000010);

        // R6: lockout with a valid header behind the bad opcode
        base = strobes;
        begin_frame(1'b0);
        sbits(24'h9F, 8);
        sbits(24'h03, 8);
        sbits(24'h000020, 24);
        sbits(24'h00, 8);
        end_frame(1'b0);
        chk("R6", "no strobe while locked", 32'(strobes - base), 32'd0);
        begin_frame(1'b0);
        sbits(24'h03, 8);
        sbits(24'h000044, 24);
        end_frame(1'b0);
        chk("R6", "reselect parses", 32'(strobes - base), 32'd1);
        chk("R6", "reselect address", 32'(cap_addr), 32'h000044);

        // R8: pause mid-address with edges during the pause
        base = strobes;
        begin_frame(1'b0);
        sbits(24'h03, 8);
        sbits(24'h000ABC, 12);
        @(negedge clk); sck = 1'b0; hold_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "io_release while paused", 32'(io_release), 32'd1);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); sck = 1'b1; si = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "io_release after pause", 32'(io_release), 32'd0);
        sbits(24'h000DEF, 12);
        chk("R8", "strobe after resume", 32'(strobes - base), 32'd1);
        chk("R8", "address ignores paused edges", 32'(cap_addr), 32'h0BCDEF);
        end_frame(1'b0);

        // R9: pause request with clock high waits for clock low
        begin_frame(1'b1);
        @(negedge clk); hold_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "pause not taken while clock high", 32'(io_release), 32'd0);
        sck = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", "pause taken once clock low", 32'(io_release), 32'd1);
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
        end_frame(1'b1);

        // R12: no strobe lasted two cycles
        chk("R12", "multi-cycle strobes", 32'(doubles), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule